// File: doc/BRIEF.md
# Burst Write Request Sequencer

This block sits between application logic and the write port of an embedded bus-master core. It takes one write request at a time. A request is a header made of an 18-bit command, a 32-bit address and a burst length, followed by that many 32-bit data words. The block turns the request into a framed stream on a FIFO-style port. An address-phase strobe frames the command and address beats. A data-phase strobe frames the data beats. A last-cycle strobe marks the closing beat of each phase.

The port runs in one of two widths. In wide mode every address and data item takes one beat. In narrow mode each 32-bit item is split into two 16-bit halves, lower half first. The halves travel on the low 16 bits of the bus, and the last-cycle strobe goes high only on the upper half that closes a phase. The command always goes out as a single beat at its full 18 bits.

During the data phase the block watches the core's write-FIFO full flag. While the flag is high it stalls and holds the pending word. The header and each data word are taken in with valid/ready handshakes.

Top module: `burst_wr_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in idle within one clock. In idle, addr_en, data_en, last_cyc and busy are low, port_data is zero and req_ready is high. This also holds when reset arrives in the middle of a request.
- R2: A header is taken in a cycle where req_valid and req_ready are both high. req_ready is high exactly when busy is low.
- R3: The first beat after a header is accepted has addr_en high and last_cyc low. Its port_data carries the command in bits 17:0, with the upper bits zero, in both modes.
- R4: wide_mode is sampled when the header is accepted. With wide_mode=1, exactly one more address-phase beat follows the command beat. It carries the full 32-bit address, with last_cyc high.
- R5: With wide_mode=0 at acceptance, two more address-phase beats follow the command beat. The first carries address bits 15:0 with last_cyc low. The second carries bits 31:16 with last_cyc high. Both use port_data bits 15:0, with bits 31:16 zero.
- R6: In the data phase addr_en is low and each beat has data_en high. Words appear in the order they were accepted on the wd interface, with none dropped or repeated. addr_en and data_en are never high together.
- R7: In narrow mode each data word takes two beats: bits 15:0 first, then bits 31:16, both on port_data bits 15:0 with bits 31:16 zero. last_cyc is high only on the upper half of the final word.
- R8: In wide mode each data word takes one beat with the full 32 bits. last_cyc is high only on the final word.
- R9: While fifo_full is high, data_en is low and the pending half or word is held until the flag clears. The address phase goes ahead regardless of fifo_full.
- R10: req_len_m1 gives the burst length minus one, so lengths run from 1 to 256. Exactly that many words are taken on the wd interface. After the burst ends, wd_ready stays low.
- R11: busy is high on every beat from the command beat through the final data beat. It is low in the cycle after the final data beat.
- R12: port_data is zero in every cycle where neither addr_en nor data_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects the 32-bit port, 0 the 16-bit port; sampled at header acceptance |
| req_valid | input | 1 | Header valid |
| req_ready | output | 1 | Header ready (block idle) |
| req_cmd | input | 18 | Command word |
| req_addr | input | 32 | Write address |
| req_len_m1 | input | 8 | Burst length minus one |
| wd_valid | input | 1 | Write word valid |
| wd_ready | output | 1 | Write word ready |
| wd_data | input | 32 | Write word |
| fifo_full | input | 1 | Core write FIFO full, active high |
| addr_en | output | 1 | Address-phase beat strobe |
| data_en | output | 1 | Data-phase beat strobe |
| last_cyc | output | 1 | Final beat of the current phase |
| port_data | output | 32 | Beat payload |
| busy | output | 1 | Request in progress |

## Verification
Bursts are run in both port widths. The lengths are the single-word minimum, the 256-word maximum and random values between them. The narrow runs show whether the halves come out in the right order and whether the last-cycle strobe lands on the right half. The single-word runs show whether the same word carries the closing strobe in both phases. The full flag is driven never, sometimes and almost always. The always-high case shows that the address phase ignores the flag, and the mixed cases show that a held word is neither lost nor sent twice. Gaps in wd_valid and a mode input toggled after acceptance check that beats follow the handshake and that the latched mode is used. A reset issued during an address phase checks recovery to idle.

// File: rtl/burst_wr_seq_pkg.sv
`timescale 1ns/1ps
package burst_wr_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CMD     = 3'd1,
      ST_ADR_LO  = 3'd2,
      ST_ADR_FIN = 3'd3,
      ST_DATA    = 3'd4
   } bws_state_e;
endpackage

// File: rtl/bws_ctrl.sv
`timescale 1ns/1ps
module bws_ctrl
   import burst_wr_seq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CMD_W     = 18,
   parameter int NARROW_EN = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [CMD_W-1:0]  req_cmd,
   input  logic [DATA_W-1:0] req_addr,
   input  logic              wide_mode,
   input  logic              data_done,
   output bws_state_e        state,
   output logic              req_ready,
   output logic              hdr_fire,
   output logic              wide_q,
   output logic [CMD_W-1:0]  cmd_q,
   output logic [DATA_W-1:0] addr_q
);
   bws_state_e nxt;

   assign req_ready = (state == ST_IDLE);
   assign hdr_fire  = req_valid && req_ready;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:    if (req_valid) nxt = ST_CMD;
         ST_CMD:     nxt = wide_q ? ST_ADR_FIN : ST_ADR_LO;
         ST_ADR_LO:  nxt = ST_ADR_FIN;
         ST_ADR_FIN: nxt = ST_DATA;
         ST_DATA:    if (data_done) nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         cmd_q  <= '0;
         addr_q <= '0;
      end else begin
         state <= nxt;
         if (hdr_fire) begin
            cmd_q  <= req_cmd;
            addr_q <= req_addr;
         end
      end
   end

   generate
      if (NARROW_EN != 0) begin : g_mode_reg
         always_ff @(posedge clk) begin
            if (rst)           wide_q <= 1'b1;
            else if (hdr_fire) wide_q <= wide_mode;
         end
      end else begin : g_mode_fixed
         logic unused_mode;
         assign unused_mode = wide_mode;
         assign wide_q      = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/bws_word_buf.sv
`timescale 1ns/1ps
module bws_word_buf #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_data,
   input  logic              hdr_fire,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic              wide_q,
   input  logic              fifo_full,
   input  logic              wd_valid,
   input  logic [DATA_W-1:0] wd_data,
   output logic              wd_ready,
   output logic              data_en,
   output logic [DATA_W-1:0] word_q,
   output logic              half_q,
   output logic              last_word_q,
   output logic              data_done
);
   localparam int CNT_W = LEN_W + 1;

   logic [CNT_W-1:0] rem_q;
   logic             have_q;
   logic             finish;
   logic             take;

   assign data_en   = in_data && have_q && !fifo_full;
   assign finish    = data_en && (wide_q || half_q);
   assign data_done = finish && last_word_q;
   assign wd_ready  = in_data && (rem_q != '0) && (!have_q || finish);
   assign take      = wd_ready && wd_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         rem_q       <= '0;
         have_q      <= 1'b0;
         half_q      <= 1'b0;
         last_word_q <= 1'b0;
         word_q      <= '0;
      end else if (hdr_fire) begin
         rem_q       <= {1'b0, len_m1} + CNT_W'(1);
         have_q      <= 1'b0;
         half_q      <= 1'b0;
         last_word_q <= 1'b0;
      end else if (take) begin
         word_q      <= wd_data;
         have_q      <= 1'b1;
         half_q      <= 1'b0;
         last_word_q <= (rem_q == CNT_W'(1));
         rem_q       <= rem_q - CNT_W'(1);
      end else if (finish) begin
         have_q <= 1'b0;
         half_q <= 1'b0;
      end else if (data_en) begin
         half_q <= 1'b1;
      end
   end
endmodule

// File: rtl/bws_port_mux.sv
`timescale 1ns/1ps
module bws_port_mux
   import burst_wr_seq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CMD_W     = 18,
   parameter int NARROW_EN = 1
) (
   input  bws_state_e        state,
   input  logic              wide_q,
   input  logic              half_q,
   input  logic              data_en,
   input  logic              last_word_q,
   input  logic [CMD_W-1:0]  cmd_q,
   input  logic [DATA_W-1:0] addr_q,
   input  logic [DATA_W-1:0] word_q,
   output logic              addr_en,
   output logic              last_cyc,
   output logic [DATA_W-1:0] port_data
);
   localparam int HALF_W = DATA_W / 2;
   localparam int PAD_W  = DATA_W - CMD_W;

   assign addr_en = (state == ST_CMD) || (state == ST_ADR_LO) || (state == ST_ADR_FIN);

   generate
      if (NARROW_EN != 0) begin : g_dual
         always_comb begin
            port_data = '0;
            last_cyc  = 1'b0;
            unique case (state)
               ST_CMD:    port_data = {{PAD_W{1'b0}}, cmd_q};
               ST_ADR_LO: port_data = {{HALF_W{1'b0}}, addr_q[HALF_W-1:0]};
               ST_ADR_FIN: begin
                  last_cyc  = 1'b1;
                  port_data = wide_q ? addr_q : {{HALF_W{1'b0}}, addr_q[DATA_W-1:HALF_W]};
               end
               ST_DATA: begin
                  if (data_en) begin
                     last_cyc = last_word_q && (wide_q || half_q);
                     if (wide_q)      port_data = word_q;
                     else if (half_q) port_data = {{HALF_W{1'b0}}, word_q[DATA_W-1:HALF_W]};
                     else             port_data = {{HALF_W{1'b0}}, word_q[HALF_W-1:0]};
                  end
               end
               default: ;
            endcase
         end
      end else begin : g_wide
         logic unused_bits;
         assign unused_bits = wide_q ^ half_q;
         always_comb begin
            port_data = '0;
            last_cyc  = 1'b0;
            unique case (state)
               ST_CMD: port_data = {{PAD_W{1'b0}}, cmd_q};
               ST_ADR_FIN: begin
                  last_cyc  = 1'b1;
                  port_data = addr_q;
               end
               ST_DATA: begin
                  if (data_en) begin
                     last_cyc  = last_word_q;
                     port_data = word_q;
                  end
               end
               default: ;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/burst_wr_seq.sv
`timescale 1ns/1ps
module burst_wr_seq
   import burst_wr_seq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CMD_W     = 18,
   parameter int LEN_W     = 8,
   parameter int NARROW_EN = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wide_mode,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CMD_W-1:0]  req_cmd,
   input  logic [DATA_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len_m1,
   input  logic              wd_valid,
   output logic              wd_ready,
   input  logic [DATA_W-1:0] wd_data,
   input  logic              fifo_full,
   output logic              addr_en,
   output logic              data_en,
   output logic              last_cyc,
   output logic [DATA_W-1:0] port_data,
   output logic              busy
);
   generate
      if (DATA_W % 2 != 0) begin : g_bad_width
         $error("burst_wr_seq: DATA_W must be even");
      end
      if (CMD_W < 1 || CMD_W >= DATA_W) begin : g_bad_cmd
         $error("burst_wr_seq: CMD_W must be in 1..DATA_W-1");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("burst_wr_seq: LEN_W must be in 1..16");
      end
   endgenerate

   bws_state_e        state;
   logic              hdr_fire;
   logic              wide_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] word_q;
   logic              half_q;
   logic              last_word_q;
   logic              data_done;
   logic              in_data;

   assign in_data = (state == ST_DATA);
   assign busy    = (state != ST_IDLE);

   bws_ctrl #(.DATA_W(DATA_W), .CMD_W(CMD_W), .NARROW_EN(NARROW_EN)) i_ctrl (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_cmd   (req_cmd),
      .req_addr  (req_addr),
      .wide_mode (wide_mode),
      .data_done (data_done),
      .state     (state),
      .req_ready (req_ready),
      .hdr_fire  (hdr_fire),
      .wide_q    (wide_q),
      .cmd_q     (cmd_q),
      .addr_q    (addr_q)
   );

   bws_word_buf #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_buf (
      .clk         (clk),
      .rst         (rst),
      .in_data     (in_data),
      .hdr_fire    (hdr_fire),
      .len_m1      (req_len_m1),
      .wide_q      (wide_q),
      .fifo_full   (fifo_full),
      .wd_valid    (wd_valid),
      .wd_data     (wd_data),
      .wd_ready    (wd_ready),
      .data_en     (data_en),
      .word_q      (word_q),
      .half_q      (half_q),
      .last_word_q (last_word_q),
      .data_done   (data_done)
   );

   bws_port_mux #(.DATA_W(DATA_W), .CMD_W(CMD_W), .NARROW_EN(NARROW_EN)) i_mux (
      .state       (state),
      .wide_q      (wide_q),
      .half_q      (half_q),
      .data_en     (data_en),
      .last_word_q (last_word_q),
      .cmd_q       (cmd_q),
      .addr_q      (addr_q),
      .word_q      (word_q),
      .addr_en     (addr_en),
      .last_cyc    (last_cyc),
      .port_data   (port_data)
   );
endmodule

// File: rtl/bws_checker.sv
`timescale 1ns/1ps
module bws_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic              addr_en,
   input logic              data_en,
   input logic              last_cyc,
   input logic              busy,
   input logic              fifo_full,
   input logic [DATA_W-1:0] port_data
);
   // R1
   reset_idle_chk: assert property (@(posedge clk) $past(rst) |-> !busy && !addr_en && !data_en);

   // R2
   ready_when_idle_chk: assert property (@(posedge clk) disable iff (rst) req_ready == !busy);

   // R3
   cmd_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_ready |=> addr_en && !last_cyc);

   // R4
   addr_phase_closed_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(addr_en) && !$past(rst) |-> $past(last_cyc));

   // R6
   enables_exclusive_chk: assert property (@(posedge clk) disable iff (rst) !(addr_en && data_en));

   // R7
   last_only_on_beat_chk: assert property (@(posedge clk) disable iff (rst)
      last_cyc |-> (addr_en || data_en));

   // R9
   full_blocks_data_chk: assert property (@(posedge clk) disable iff (rst) fifo_full |-> !data_en);

   // R11
   busy_on_beat_chk: assert property (@(posedge clk) disable iff (rst) (addr_en || data_en) |-> busy);

   // R12
   idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !(addr_en || data_en) |-> port_data == '0);
endmodule

bind burst_wr_seq bws_checker #(.DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .addr_en   (addr_en),
   .data_en   (data_en),
   .last_cyc  (last_cyc),
   .busy      (busy),
   .fifo_full (fifo_full),
   .port_data (port_data)
);

// File: tb/test_burst_wr_seq.sv
`timescale 1ns/1ps
module test_burst_wr_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wide_mode = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [17:0] req_cmd = '0;
   logic [31:0] req_addr = '0;
   logic [7:0]  req_len_m1 = '0;
   logic        wd_valid = 1'b0;
   logic        wd_ready;
   logic [31:0] wd_data = '0;
   logic        fifo_full = 1'b0;
   logic        addr_en, data_en, last_cyc, busy;
   logic [31:0] port_data;

   int  n_chk = 0;
   int  n_err = 0;
   bit  finished = 1'b0;

   logic [31:0] t_words [0:255];
   logic [17:0] t_cmd;
   logic [31:0] t_addr;
   int          t_len;
   bit          t_wide;

   burst_wr_seq i_burst_wr_seq (
      .clk(clk), .rst(rst), .wide_mode(wide_mode), .req_valid(req_valid), .req_ready(req_ready),
      .req_cmd(req_cmd), .req_addr(req_addr), .req_len_m1(req_len_m1), .wd_valid(wd_valid),
      .wd_ready(wd_ready), .wd_data(wd_data), .fifo_full(fifo_full), .addr_en(addr_en),
      .data_en(data_en), .last_cyc(last_cyc), .port_data(port_data), .busy(busy)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
      end
   endtask

   function automatic int exp_total();
      return t_wide ? (2 + t_len) : (3 + 2 * t_len);
   endfunction

   // beat k of the request: {is_address_phase, last, payload}
   function automatic logic [33:0] exp_beat(input int k);
      int j;
      logic [31:0] w;
      if (k == 0) return {2'b10, 14'd0, t_cmd};
      if (t_wide) begin
         if (k == 1) return {2'b11, t_addr};
         j = k - 2;
         return {1'b0, (j == t_len - 1), t_words[j]};
      end
      if (k == 1) return {2'b10, 16'd0, t_addr[15:0]};
      if (k == 2) return {2'b11, 16'd0, t_addr[31:16]};
      j = k - 3;
      w = t_words[j / 2];
      if (j % 2 == 0) return {2'b00, 16'd0, w[15:0]};
      return {1'b0, (j / 2 == t_len - 1), 16'd0, w[31:16]};
   endfunction

   task automatic run_txn(input logic [17:0] cmd, input logic [31:0] addr, input int len,
                          input bit wide, input int pfull, input int pgap);
      int nb = 0, wi = 0, cyc = 0, total, n_adr;
      bit hdr = 1'b0;
      int e_cmd = 0, e_adr = 0, e_dat = 0, v_full = 0, v_zero = 0, v_rdy = 0, v_busy = 0;
      logic [33:0] obs, expb, a_cmd = '0, x_cmd = '0, a_adr = '0, x_adr = '0, a_dat = '0, x_dat = '0;
      t_cmd = cmd; t_addr = addr; t_len = len; t_wide = wide;
      for (int i = 0; i < len; i++) t_words[i] = $urandom;
      total = exp_total();
      n_adr = wide ? 2 : 3;
      while (nb < total && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         fifo_full = (($urandom % 100) < pfull);
         if (!hdr) begin
            req_valid = 1'b1; req_cmd = cmd; req_addr = addr;
            req_len_m1 = 8'(len - 1); wide_mode = wide;
         end else begin
            req_valid = 1'b0; req_cmd = 18'($urandom); req_addr = $urandom;
            wide_mode = 1'($urandom);
         end
         wd_valid = hdr && (wi < len) && (($urandom % 100) >= pgap);
         wd_data  = (wi < len) ? t_words[wi] : $urandom;
         #1;
         if (req_ready != !busy) v_rdy++;
         if (data_en && fifo_full) v_full++;
         if (!(addr_en || data_en) && port_data != 32'd0) v_zero++;
         if (addr_en || data_en) begin
            obs  = {addr_en, last_cyc, port_data};
            expb = exp_beat(nb);
            if (!busy) v_busy++;
            if (obs != expb) begin
               if (nb == 0) begin if (e_cmd == 0) begin a_cmd = obs; x_cmd = expb; end e_cmd++; end
               else if (nb < n_adr) begin if (e_adr == 0) begin a_adr = obs; x_adr = expb; end e_adr++; end
               else begin if (e_dat == 0) begin a_dat = obs; x_dat = expb; end e_dat++; end
            end
            nb++;
         end
         if (req_valid && req_ready) hdr = 1'b1;
         if (wd_valid && wd_ready) wi++;
      end
      // one cycle after the final beat, with a spare word offered
      @(negedge clk);
      req_valid = 1'b0; fifo_full = 1'b0; wd_valid = 1'b1; wd_data = $urandom;
      #1;
      chk(cyc < 4000, "R10 burst completes", 64'(nb), 64'(total));
      chk(e_cmd == 0, "R3 command beat", 64'(a_cmd), 64'(x_cmd));
      chk(e_adr == 0, wide ? "R4 wide address beat" : "R5 narrow address halves", 64'(a_adr), 64'(x_adr));
      chk(e_dat == 0, wide ? "R6 R8 wide data beats" : "R6 R7 narrow data halves", 64'(a_dat), 64'(x_dat));
      chk(wi == len, "R10 words taken", 64'(wi), 64'(len));
      chk(!wd_ready, "R10 no extra word taken", 64'(wd_ready), 64'd0);
      chk(v_full == 0, "R9 data_en low while full", 64'(v_full), 64'd0);
      chk(v_zero == 0, "R12 bus zero between beats", 64'(v_zero), 64'd0);
      chk(v_rdy == 0, "R2 ready tracks idle", 64'(v_rdy), 64'd0);
      chk(v_busy == 0, "R11 busy on every beat", 64'(v_busy), 64'd0);
      chk(!busy && !addr_en && !data_en && port_data == 32'd0, "R11 busy low after last beat",
          {busy, addr_en, data_en, port_data}, 64'd0);
      wd_valid = 1'b0;
   endtask

   task automatic chk_idle(input string what);
      chk(!addr_en && !data_en && !last_cyc && !busy && port_data == 32'd0 && req_ready, what,
          {req_ready, addr_en, data_en, last_cyc, busy, port_data}, {1'b1, 36'd0});
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      #1;
      chk_idle("R1 idle after reset");

      // directed corners
      run_txn(18'h3FFFF, 32'hFFFF_0000, 1,   1'b1, 0,  0);
      run_txn(18'h2AAAA, 32'h1234_5678, 1,   1'b0, 0,  0);
      run_txn(18'h00001, 32'hDEAD_BEEF, 256, 1'b1, 0,  0);
      run_txn(18'h15555, 32'h0000_FFFF, 256, 1'b0, 20, 10);
      run_txn(18'h0ABCD, 32'hCAFE_F00D, 4,   1'b1, 90, 0);
      run_txn(18'h1F00F, 32'h8000_0001, 4,   1'b0, 90, 30);
      run_txn(18'h00000, 32'h0000_0000, 3,   1'b0, 0,  70);

      // reset during the address phase
      @(negedge clk);
      req_valid = 1'b1; req_cmd = 18'h12345; req_addr = 32'h5555_AAAA; req_len_m1 = 8'd7; wide_mode = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk_idle("R1 idle after reset mid request");
      run_txn(18'h2468A, 32'h1357_9BDF, 2, 1'b0, 30, 30);

      // constrained random mix
      for (int n = 0; n < 24; n++) begin
         run_txn(18'($urandom), $urandom, 1 + ($urandom % 48), 1'($urandom),
                 $urandom % 60, $urandom % 50);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog R10 run did not finish actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule